// File: doc/BRIEF.md
# Multiframe Receive Descriptor Queue

This block is the receive-side descriptor engine placed behind an E1 framer. Software hands it buffer descriptors, each naming one multiframe slot of a shared frame buffer. When the framer reports the first byte of a multiframe (frame 0, timeslot 0), the engine takes the oldest pending descriptor. It then writes all 512 bytes of that multiframe (16 frames of 32 timeslots) into the slot. After the final byte it returns the descriptor, marked valid and carrying the CRC-4 outcome of both submultiframes, to a completion queue that software drains.

Both queues sit behind a single descriptor register. A write to it queues a new descriptor and a read from it removes the oldest completed one. A second register holds the enable bit and the alignment mode, which are handed on to the framer. When read, that register returns status: enable, line alignment, the four queue empty/full flags and a sticky overflow flag. Line decoding, frame alignment and the CRC-4 computation are outside the block. Their results arrive on input pins.

Top module: `mf_desc_queue`

## Requirements
- R1: A write with `reg_sel`=1 queues `reg_wdata[6:0]` as a slot number in the pending queue. The queue is 4 entries deep, and a write to a full pending queue is ignored. Status bit 8 is set when the pending queue is empty and bit 9 when it is full.
- R2: A read with `reg_sel`=1 presents the oldest completed descriptor on `reg_rdata` and removes it at the clock edge, so completions come out in order. With no completion pending the read returns 16'h0000, which has bit 15 clear.
- R3: On a byte strobe for frame 0, timeslot 0 while enabled and with a pending descriptor, the engine claims the oldest pending slot. Each byte of that multiframe is written to `mem_addr` = (slot << 9) | (frame << 5) | timeslot. Bytes seen before any claim are not written.
- R4: On the byte of frame 15, timeslot 31, the descriptor is retired to the completion queue and can be read from the next cycle. The completed word has bit 15 = valid, bit 14 = CRC of half 1, bit 13 = CRC of half 0, bits 6:0 = slot, and all other bits 0.
- R5: A CRC bit is 1 only if, during that multiframe, a CRC result with `crc_ok`=1 was reported for its half (`crc_half`=0 maps to bit 13, `crc_half`=1 maps to bit 14). A result reported in the same cycle as the last byte still counts.
- R6: Status bit 12 is set, and stays set, when a multiframe starts with the pending queue empty. It is also set when a retirement finds the completion queue full. In the first case nothing of that multiframe is written, and in the second the descriptor is dropped.
- R7: A write with `reg_sel`=0 loads the enable from bit 0 and the mode from bits 2:1 (0 transparent, 1 byte, 2 basic frame, 3 multiframe). These appear on `cfg_en` and `cfg_mode`. Writing 1 to bit 12 clears the overflow flag, and a new overflow event in the same cycle wins over the clear.
- R8: A read with `reg_sel`=0 returns status: bit 0 = enabled, bit 1 = `line_aligned`, bit 10 = completion queue empty, bit 11 = completion queue full, plus bits 8, 9 and 12 as above. All other bits read 0.
- R9: While disabled, byte strobes write nothing, claim no descriptor and raise no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 = control/status, 1 = descriptor register |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| line_aligned | input | 1 | Framer alignment indication |
| byte_vld | input | 1 | Received byte strobe |
| byte_frame | input | 4 | Frame number of the byte within its multiframe |
| byte_ts | input | 5 | Timeslot number of the byte |
| byte_data | input | 8 | Received byte |
| crc_vld | input | 1 | CRC-4 result strobe |
| crc_half | input | 1 | Submultiframe the result belongs to |
| crc_ok | input | 1 | 1 when the computed CRC-4 matched |
| cfg_en | output | 1 | Enable handed to the framer |
| cfg_mode | output | 2 | Alignment mode handed to the framer |
| mem_we | output | 1 | Frame buffer write enable |
| mem_addr | output | 16 | Frame buffer byte address |
| mem_wdata | output | 8 | Frame buffer write data |

## Verification
The bench uses the default build: queues 4 deep, 7-bit slot numbers and the full 16×32 multiframe geometry. With this build every byte of every multiframe can be checked against an address and data value computed in the bench. A handful of pushes is enough to fill either queue, so both the ignored fifth push and both overflow causes are reached within a dozen multiframes. The bench runs all four combinations of CRC results, uses slot numbers at the edges of the 7-bit range, joins in the middle of a multiframe, and runs a multiframe while disabled.

// File: rtl/mfdq_pkg.sv
package mfdq_pkg;
   localparam int REG_W        = 16;
   // control fields
   localparam int CTL_EN       = 0;
   localparam int CTL_MODE_LO  = 1;
   localparam int CTL_OVF_CLR  = 12;
   // status fields
   localparam int ST_EN        = 0;
   localparam int ST_ALIGN     = 1;
   localparam int ST_IN_EMPTY  = 8;
   localparam int ST_IN_FULL   = 9;
   localparam int ST_OUT_EMPTY = 10;
   localparam int ST_OUT_FULL  = 11;
   localparam int ST_OVF       = 12;
   // completed descriptor fields
   localparam int DESC_VALID   = 15;
   localparam int DESC_CRC1    = 14;
   localparam int DESC_CRC0    = 13;

   typedef enum logic [1:0] {
      MODE_RAW    = 2'd0,
      MODE_OCTET  = 2'd1,
      MODE_FRAME  = 2'd2,
      MODE_MFRAME = 2'd3
   } align_mode_e;
endpackage

// File: rtl/mfdq_fifo.sv
module mfdq_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4,
   parameter int LW    = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  wdat,
   input  logic          pop,
   output logic [W-1:0]  rdat,
   output logic          empty,
   output logic          full,
   output logic [LW-1:0] level
);
   localparam int PW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("mfdq_fifo: DEPTH must be a power of two of at least 2");
   end
   if (LW != PW + 1) begin : g_bad_lw
      $error("mfdq_fifo: LW must be clog2(DEPTH)+1");
   end

   logic [W-1:0] store [DEPTH];
   logic [PW:0]  wp, rp;
   logic         do_push, do_pop;

   assign level   = wp - rp;
   assign empty   = (level == '0);
   assign full    = (level == LW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdat    = store[rp[PW-1:0]];

   always_ff @(posedge clk) begin
      if (do_push) store[wp[PW-1:0]] <= wdat;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
      end
   end
endmodule

// File: rtl/mfdq_fill.sv
module mfdq_fill
   import mfdq_pkg::*;
#(
   parameter int SLOT_W = 7,
   parameter int FRM_W  = 4,
   parameter int TS_W   = 5
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           en,
   input  logic                           byte_vld,
   input  logic [FRM_W-1:0]               byte_frame,
   input  logic [TS_W-1:0]                byte_ts,
   input  logic [7:0]                     byte_data,
   input  logic                           crc_vld,
   input  logic                           crc_half,
   input  logic                           crc_ok,
   input  logic                           in_empty,
   input  logic [SLOT_W-1:0]              in_slot,
   input  logic                           out_full,
   output logic                           in_pop,
   output logic                           out_push,
   output logic [REG_W-1:0]               out_desc,
   output logic                           ovf_evt,
   output logic                           mem_we,
   output logic [SLOT_W+FRM_W+TS_W-1:0]   mem_addr,
   output logic [7:0]                     mem_wdata
);
   if (SLOT_W < 1 || SLOT_W > DESC_CRC0) begin : g_bad_slot
      $error("mfdq_fill: slot number does not fit below the CRC flags");
   end

   logic              act_q;
   logic [SLOT_W-1:0] act_slot_q;
   logic [1:0]        crc_q, crc_n;
   logic              first_b, last_b, start, claim, writing, retire;
   logic [SLOT_W-1:0] cur_slot;

   assign first_b  = byte_vld && (byte_frame == '0) && (byte_ts == '0);
   assign last_b   = byte_vld && (&byte_frame) && (&byte_ts);
   assign start    = en && first_b;
   assign claim    = start && !in_empty;
   assign writing  = en && byte_vld && (first_b ? claim : act_q);
   assign retire   = writing && last_b;
   assign cur_slot = first_b ? in_slot : act_slot_q;

   assign in_pop    = claim;
   assign out_push  = retire && !out_full;
   assign ovf_evt   = (start && in_empty) || (retire && out_full);
   assign mem_we    = writing;
   assign mem_addr  = {cur_slot, byte_frame, byte_ts};
   assign mem_wdata = byte_data;

   always_comb begin
      crc_n = first_b ? 2'b00 : crc_q;
      if (crc_vld && crc_ok) crc_n[crc_half] = 1'b1;
   end

   always_comb begin
      out_desc                   = '0;
      out_desc[DESC_VALID]       = 1'b1;
      out_desc[DESC_CRC1]        = crc_n[1];
      out_desc[DESC_CRC0]        = crc_n[0];
      out_desc[SLOT_W-1:0]       = act_slot_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q      <= 1'b0;
         act_slot_q <= '0;
         crc_q      <= 2'b00;
      end else if (!en) begin
         act_q      <= 1'b0;
         crc_q      <= 2'b00;
      end else begin
         crc_q <= crc_n;
         if (start) begin
            act_q <= claim;
            if (claim) act_slot_q <= in_slot;
         end else if (retire) begin
            act_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/mf_desc_queue.sv
module mf_desc_queue
   import mfdq_pkg::*;
#(
   parameter int DEPTH  = 4,
   parameter int SLOT_W = 7,
   parameter int FRM_W  = 4,
   parameter int TS_W   = 5
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         reg_wr,
   input  logic                         reg_rd,
   input  logic                         reg_sel,
   input  logic [15:0]                  reg_wdata,
   output logic [15:0]                  reg_rdata,
   input  logic                         line_aligned,
   input  logic                         byte_vld,
   input  logic [FRM_W-1:0]             byte_frame,
   input  logic [TS_W-1:0]              byte_ts,
   input  logic [7:0]                   byte_data,
   input  logic                         crc_vld,
   input  logic                         crc_half,
   input  logic                         crc_ok,
   output logic                         cfg_en,
   output logic [1:0]                   cfg_mode,
   output logic                         mem_we,
   output logic [SLOT_W+FRM_W+TS_W-1:0] mem_addr,
   output logic [7:0]                   mem_wdata
);
   localparam int LW = $clog2(DEPTH) + 1;

   if (REG_W != 16) begin : g_bad_reg
      $error("mf_desc_queue: register width must be 16");
   end

   logic              ctl_wr, desc_wr, desc_rd;
   logic              en_q, ovf_q;
   align_mode_e       mode_q;
   logic              in_empty, in_full, in_pop;
   logic [SLOT_W-1:0] in_slot;
   logic [LW-1:0]     in_level;
   logic              out_empty, out_full, out_push;
   logic [REG_W-1:0]  out_desc, out_head;
   logic [LW-1:0]     out_level;
   logic              ovf_evt;
   logic [REG_W-1:0]  status;
   logic              unused_bits;

   assign ctl_wr  = reg_wr && !reg_sel;
   assign desc_wr = reg_wr && reg_sel;
   assign desc_rd = reg_rd && reg_sel;
   assign unused_bits = ^{reg_wdata, in_level, out_level};

   mfdq_fifo #(.W(SLOT_W), .DEPTH(DEPTH), .LW(LW)) u_pend (
      .clk(clk), .rst_n(rst_n),
      .push(desc_wr), .wdat(reg_wdata[SLOT_W-1:0]),
      .pop(in_pop), .rdat(in_slot),
      .empty(in_empty), .full(in_full), .level(in_level)
   );

   mfdq_fifo #(.W(REG_W), .DEPTH(DEPTH), .LW(LW)) u_done (
      .clk(clk), .rst_n(rst_n),
      .push(out_push), .wdat(out_desc),
      .pop(desc_rd), .rdat(out_head),
      .empty(out_empty), .full(out_full), .level(out_level)
   );

   mfdq_fill #(.SLOT_W(SLOT_W), .FRM_W(FRM_W), .TS_W(TS_W)) u_fill (
      .clk(clk), .rst_n(rst_n), .en(en_q),
      .byte_vld(byte_vld), .byte_frame(byte_frame), .byte_ts(byte_ts),
      .byte_data(byte_data),
      .crc_vld(crc_vld), .crc_half(crc_half), .crc_ok(crc_ok),
      .in_empty(in_empty), .in_slot(in_slot), .out_full(out_full),
      .in_pop(in_pop), .out_push(out_push), .out_desc(out_desc),
      .ovf_evt(ovf_evt),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mode_q <= MODE_RAW;
         ovf_q  <= 1'b0;
      end else begin
         if (ctl_wr) begin
            en_q   <= reg_wdata[CTL_EN];
            mode_q <= align_mode_e'(reg_wdata[CTL_MODE_LO +: 2]);
         end
         if (ovf_evt)
            ovf_q <= 1'b1;
         else if (ctl_wr && reg_wdata[CTL_OVF_CLR])
            ovf_q <= 1'b0;
      end
   end

   always_comb begin
      status               = '0;
      status[ST_EN]        = en_q;
      status[ST_ALIGN]     = line_aligned;
      status[ST_IN_EMPTY]  = in_empty;
      status[ST_IN_FULL]   = in_full;
      status[ST_OUT_EMPTY] = out_empty;
      status[ST_OUT_FULL]  = out_full;
      status[ST_OVF]       = ovf_q;
   end

   assign reg_rdata = reg_sel ? (out_empty ? '0 : out_head) : status;
   assign cfg_en    = en_q;
   assign cfg_mode  = mode_q;
endmodule

// File: rtl/mfdq_checker.sv
module mfdq_checker #(
   parameter int FRM_W = 4,
   parameter int TS_W  = 5,
   parameter int AW    = 16,
   parameter int LW    = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic             reg_rd,
   input logic             reg_sel,
   input logic [15:0]      reg_wdata,
   input logic [15:0]      reg_rdata,
   input logic             byte_vld,
   input logic [FRM_W-1:0] byte_frame,
   input logic [TS_W-1:0]  byte_ts,
   input logic             mem_we,
   input logic [AW-1:0]    mem_addr,
   input logic             en_q,
   input logic             ovf_q,
   input logic             in_empty,
   input logic             in_full,
   input logic             in_pop,
   input logic [LW-1:0]    in_level,
   input logic             out_empty
);
   AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (en_q && byte_vld)); // R9

   AST_ADDR_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr[FRM_W+TS_W-1:TS_W] == byte_frame && mem_addr[TS_W-1:0] == byte_ts)); // R3

   AST_FULL_PUSH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel && in_full && !in_pop) |=> $stable(in_level)); // R1

   AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_sel && out_empty) |-> (reg_rdata == 16'h0000)); // R2

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !(reg_wr && !reg_sel && reg_wdata[12])) |=> ovf_q); // R6

   AST_OVF_ON_STARVE: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && byte_vld && byte_frame == '0 && byte_ts == '0 && in_empty) |=> ovf_q); // R6
endmodule

bind mf_desc_queue mfdq_checker #(
   .FRM_W(FRM_W), .TS_W(TS_W), .AW(SLOT_W + FRM_W + TS_W), .LW(LW)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
   .byte_vld(byte_vld), .byte_frame(byte_frame), .byte_ts(byte_ts),
   .mem_we(mem_we), .mem_addr(mem_addr),
   .en_q(en_q), .ovf_q(ovf_q),
   .in_empty(in_empty), .in_full(in_full), .in_pop(in_pop),
   .in_level(in_level), .out_empty(out_empty)
);

// File: tb/sim_mf_desc_queue.sv
module sim_mf_desc_queue;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        line_aligned = 1'b0;
   logic        byte_vld = 1'b0;
   logic [3:0]  byte_frame = '0;
   logic [4:0]  byte_ts = '0;
   logic [7:0]  byte_data = '0;
   logic        crc_vld = 1'b0, crc_half = 1'b0, crc_ok = 1'b0;
   logic        cfg_en;
   logic [1:0]  cfg_mode;
   logic        mem_we;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mf_desc_queue u0 (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .line_aligned(line_aligned),
      .byte_vld(byte_vld), .byte_frame(byte_frame), .byte_ts(byte_ts),
      .byte_data(byte_data),
      .crc_vld(crc_vld), .crc_half(crc_half), .crc_ok(crc_ok),
      .cfg_en(cfg_en), .cfg_mode(cfg_mode),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_write(input bit sel, input logic [15:0] d);
      reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input bit sel, output logic [15:0] d);
      reg_sel = sel; reg_rd = 1'b1;
      #2 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic expect_status(input logic [15:0] exp, input string req);
      logic [15:0] v;
      reg_read(1'b0, v);
      check(v == exp, req, v, exp);
   endtask

   task automatic expect_desc(input logic [15:0] exp, input string req);
      logic [15:0] v;
      reg_read(1'b1, v);
      check(v == exp, req, v, exp);
   endtask

   // one multiframe from frame f0; crc bit0 reported for half 0, bit1 for half 1
   task automatic send_mf(input int mfn, input logic [1:0] crc, input bit exp_wr,
                          input int slot, input int f0, input string req);
      int errs = 0;
      for (int f = f0; f < 16; f++) begin
         for (int ts = 0; ts < 32; ts++) begin
            byte_vld   = 1'b1;
            byte_frame = 4'(f);
            byte_ts    = 5'(ts);
            byte_data  = 8'((mfn * 7 + f * 32 + ts) & 8'hff);
            crc_vld    = (ts == 31) && (f == 7 || f == 15);
            crc_half   = (f == 15);
            crc_ok     = (f == 15) ? crc[1] : crc[0];
            #2;
            if (mem_we !== exp_wr) errs++;
            else if (exp_wr && (mem_addr !== 16'((slot << 9) | (f << 5) | ts)
                                || mem_wdata !== byte_data)) errs++;
            @(negedge clk);
         end
      end
      byte_vld = 1'b0; crc_vld = 1'b0;
      check(errs == 0, req, errs, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int slots_a[4] = '{3, 17, 64, 127};
      int slots_b[4] = '{1, 2, 4, 8};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      expect_status(16'h0500, "R8 reset status");
      expect_desc(16'h0000, "R2 empty read after reset");

      // control: enable, multiframe mode
      reg_write(1'b0, 16'h0007);
      check(cfg_en == 1'b1 && cfg_mode == 2'd3, "R7 cfg outputs", {cfg_en, cfg_mode}, 3'b111);
      expect_status(16'h0501, "R8 enabled status");
      line_aligned = 1'b1;
      expect_status(16'h0503, "R8 aligned bit");

      // fill pending queue, then one extra push that must be ignored
      foreach (slots_a[i]) reg_write(1'b1, 16'(slots_a[i]));
      expect_status(16'h0603, "R1 pending full");
      reg_write(1'b1, 16'd42);

      // four multiframes sweeping all CRC patterns
      for (int k = 0; k < 4; k++)
         send_mf(k, 2'(k), 1'b1, slots_a[k], 0, "R3 bytes of claimed multiframe");
      expect_status(16'h0903, "R8 completion full, pending empty");

      // starved multiframe: the ignored 5th push must not be used
      send_mf(4, 2'b11, 1'b0, 0, 0, "R1 R6 starved multiframe dropped");
      expect_status(16'h1903, "R6 overflow flag set");

      for (int k = 0; k < 4; k++)
         expect_desc(16'h8000 | 16'(k << 13) | 16'(slots_a[k]), "R4 R5 completed descriptor");
      expect_desc(16'h0000, "R2 empty after draining");
      expect_status(16'h1503, "R6 overflow sticky");

      // clear overflow
      reg_write(1'b0, 16'h1007);
      expect_status(16'h0503, "R7 overflow cleared");

      // overflow through full completion queue
      foreach (slots_b[i]) reg_write(1'b1, 16'(slots_b[i]));
      for (int k = 0; k < 4; k++)
         send_mf(10 + k, 2'b11, 1'b1, slots_b[k], 0, "R3 second round bytes");
      reg_write(1'b1, 16'd16);
      send_mf(20, 2'b11, 1'b1, 16, 0, "R3 multiframe into slot 16");
      expect_status(16'h1903, "R6 overflow on full completion queue");
      for (int k = 0; k < 4; k++)
         expect_desc(16'hE000 | 16'(slots_b[k]), "R6 R4 earlier completions kept");
      expect_desc(16'h0000, "R6 dropped descriptor absent");

      // disabled: no write, no claim, no overflow
      reg_write(1'b0, 16'h1000);
      check(cfg_en == 1'b0 && cfg_mode == 2'd0, "R7 disable outputs", {cfg_en, cfg_mode}, 0);
      expect_status(16'h0502, "R7 disabled and cleared");
      reg_write(1'b1, 16'd33);
      expect_status(16'h0402, "R1 one pending");
      send_mf(30, 2'b11, 1'b0, 0, 0, "R9 disabled multiframe ignored");
      expect_status(16'h0402, "R9 no claim no overflow");

      // enable mid-multiframe: partial bytes unwritten, then a full one
      reg_write(1'b0, 16'h0007);
      send_mf(31, 2'b00, 1'b0, 0, 8, "R3 no write before a claim");
      expect_status(16'h0403, "R3 no claim mid multiframe");
      send_mf(32, 2'b10, 1'b1, 33, 0, "R3 multiframe into slot 33");
      expect_status(16'h0103, "R8 completion pending");
      expect_desc(16'hC021, "R5 only half 1 CRC ok");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule